// File: doc/BRIEF.md
# Four-Scheme Quadrature Carrier Modulator

This block turns a stream of 8-bit symbols into two streams of signed carrier samples, one for an in-phase converter and one for a quadrature converter. A four-line push-button vector picks one of four constellations: binary phase, four-phase, 16-point or 256-point quadrature amplitude. Each symbol becomes an I and a Q amplitude, and these are multiplied with cosine and sine samples from an internal 64-step carrier generator.

One carrier cycle is 64 clocks, one sample per clock, and each carrier cycle carries exactly one symbol. The block raises `sym_req` in the last clock of every cycle. A source that drives `sym_valid` with a symbol in that clock has it transmitted for the whole next cycle. The button setting is sampled in the same clock. All amplitudes, carrier samples and outputs are signed fixed point with 10 fraction bits in a 15-bit word, so the value 1.0 is 1024.

Top module: `qam_carrier_mod`

## Requirements
- R1: The button vector `btn[3:0]` selects the scheme. 4'b0100 selects four-phase, 4'b0010 selects 16-point and 4'b0001 selects 256-point. 4'b1000, 4'b0000 and every other pattern select binary phase.
- R2: A phase counter restarts at 0 after reset and wraps every 64 clocks. `sym_req` is high only while the counter is 63. A symbol present with `sym_valid` high in that clock is used for the following 64 samples.
- R3: The scheme is taken from `btn` only in the `sym_req` clock. Button changes at any other time do not affect the samples of the current symbol.
- R4: If `sym_valid` is low in the `sym_req` clock, both outputs are 0 for the next 64 samples. A `sym_valid` pulse outside that clock is ignored.
- R5: Binary phase: bit 0 gives I = +0.125 (128) when 1 and -0.125 (-128) when 0. Q is 0.
- R6: Four-phase: bit 1 drives I and bit 0 drives Q. Each axis is +0.1875 (192) when its bit is 1 and -0.1875 when it is 0.
- R7: 16-point: bits [3:2] drive I and bits [1:0] drive Q. Each axis maps 00 to -0.875, 01 to -0.3125, 11 to +0.3125 and 10 to +0.875.
- R8: 256-point: bits [7:4] drive I and bits [3:0] drive Q. Each nibble maps to an odd level L (times 1024) as follows: 0001 -15, 0000 -13, 0010 -11, 0011 -9, 0111 -7, 0110 -5, 0100 -3, 0101 -1, 1101 +1, 1100 +3, 1110 +5, 1111 +7, 1011 +9, 1010 +11, 1000 +13, 1001 +15.
- R9: The carrier at phase k is c(k) = round(1024*sin(2*pi*k/64)) for the sine branch and round(1024*cos(2*pi*k/64)) for the cosine branch. I multiplies the cosine and Q multiplies the sine.
- R10: The output for phase k appears one clock after the counter holds k. It equals (A*c + 512) >>> 10, which rounds half up to 10 fraction bits. Its magnitude never exceeds 15360.
- R11: During and right after reset both outputs are 0 and `sym_req` is low. The first `sym_req` comes 63 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one carrier sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| btn | input | 4 | Scheme buttons, one-hot or idle |
| sym_valid | input | 1 | A symbol is offered in this clock |
| sym_data | input | 8 | Symbol bits |
| sym_req | output | 1 | High in the clock where a symbol is taken |
| mod_i | output | 15 | In-phase modulated sample, signed Q5.10 |
| mod_q | output | 15 | Quadrature modulated sample, signed Q5.10 |

## Verification
A faulty phase counter shows up in the first clock it goes wrong. `sym_req` falls out of its 64-clock rhythm and the carrier shape departs from the sine table. A wrong amplitude or a scheme register that took a button change too early corrupts every sample of that symbol, starting one clock after the capture edge. The bench therefore compares all 64 samples of each symbol. A symbol register that is not cleared when no symbol is offered leaves nonzero output in a cycle that must be silent.

// File: rtl/qam_mod_pkg.sv
// Shared constants and the scheme encoding for the carrier modulator.
package qam_mod_pkg;
    localparam int BTN_W   = 4;   // button lines
    localparam int SYM_W   = 8;   // bits per symbol
    localparam int PHASE_W = 6;   // 64 samples per carrier cycle

    typedef enum logic [1:0] {
        SCH_BPSK   = 2'd0,
        SCH_QPSK   = 2'd1,
        SCH_QAM16  = 2'd2,
        SCH_QAM256 = 2'd3
    } scheme_e;
endpackage

// File: rtl/qam_scheme_decode.sv
// Decodes the button vector into a scheme code.
// Assumes: btn[3] is the first button; any pattern other than a single
// press of buttons 2..4 falls back to binary phase.
module qam_scheme_decode
    import qam_mod_pkg::*;
(
    input  logic [BTN_W-1:0] btn,
    output scheme_e          scheme
);
    // Map each recognised pattern, default to the binary-phase scheme.
    always_comb begin
        case (btn)
            4'b0100: scheme = SCH_QPSK;
            4'b0010: scheme = SCH_QAM16;
            4'b0001: scheme = SCH_QAM256;
            default: scheme = SCH_BPSK;
        endcase
    end
endmodule

// File: rtl/qam_level_map.sv
// Maps a symbol to I and Q amplitudes for the selected scheme.
// Assumes: FRAC_W >= 4 so every level is exact; amplitudes are zero
// when no symbol is live.
module qam_level_map
    import qam_mod_pkg::*;
#(
    parameter int SAMP_W = 15,
    parameter int FRAC_W = 10
) (
    input  scheme_e                  scheme,
    input  logic [SYM_W-1:0]         sym,
    input  logic                     live,
    output logic signed [SAMP_W-1:0] amp_i,
    output logic signed [SAMP_W-1:0] amp_q
);
    localparam int ONE    = 1 << FRAC_W;
    localparam int A_BPSK = ONE / 8;          // 0.125
    localparam int A_QPSK = (ONE * 3) / 16;   // 0.1875
    localparam int A_INN  = (ONE * 5) / 16;   // 0.3125
    localparam int A_OUT  = (ONE * 7) / 8;    // 0.875

    // Signed level from a polarity bit and a magnitude.
    function automatic logic signed [SAMP_W-1:0] polar(input logic pos, input int mag);
        return pos ? SAMP_W'(mag) : SAMP_W'(-mag);
    endfunction

    // 16-point axis: high bit is polarity, low bit picks the inner level.
    function automatic logic signed [SAMP_W-1:0] lvl16(input logic [1:0] b);
        return polar(b[1], b[0] ? A_INN : A_OUT);
    endfunction

    // 256-point axis: undo the offset Gray code, then level = 2k - 15.
    function automatic logic signed [SAMP_W-1:0] lvl256(input logic [3:0] n);
        logic [3:0] g;
        logic [3:0] k;
        g    = n ^ 4'b0001;
        k[3] = g[3];
        k[2] = k[3] ^ g[2];
        k[1] = k[2] ^ g[1];
        k[0] = k[1] ^ g[0];
        return SAMP_W'((2 * int'(k) - 15) * ONE);
    endfunction

    // Pick the axis amplitudes for the live scheme.
    always_comb begin
        amp_i = '0;
        amp_q = '0;
        if (live) begin
            case (scheme)
                SCH_BPSK: amp_i = polar(sym[0], A_BPSK);
                SCH_QPSK: begin
                    amp_i = polar(sym[1], A_QPSK);
                    amp_q = polar(sym[0], A_QPSK);
                end
                SCH_QAM16: begin
                    amp_i = lvl16(sym[3:2]);
                    amp_q = lvl16(sym[1:0]);
                end
                default: begin
                    amp_i = lvl256(sym[7:4]);
                    amp_q = lvl256(sym[3:0]);
                end
            endcase
        end
    end
endmodule

// File: rtl/qam_carrier_nco.sv
// Free-running 64-step carrier generator with cosine and sine outputs.
// Assumes: FRAC_W >= 10; the quarter-wave table holds unit amplitude at
// 10 fraction bits and is shifted up for wider fractions.
module qam_carrier_nco
    import qam_mod_pkg::*;
#(
    parameter int SAMP_W = 15,
    parameter int FRAC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     slot,
    output logic signed [SAMP_W-1:0] cos_s,
    output logic signed [SAMP_W-1:0] sin_s
);
    localparam logic [PHASE_W-1:0] QTR = PHASE_W'(1 << (PHASE_W - 2));

    logic [PHASE_W-1:0] phase;

    // First quadrant of the unit sine, 17 points.
    function automatic logic signed [SAMP_W-1:0] quarter(input logic [4:0] idx);
        int v;
        case (idx)
            5'd0:  v = 0;    5'd1:  v = 100;  5'd2:  v = 200;  5'd3:  v = 297;
            5'd4:  v = 392;  5'd5:  v = 483;  5'd6:  v = 569;  5'd7:  v = 650;
            5'd8:  v = 724;  5'd9:  v = 792;  5'd10: v = 851;  5'd11: v = 903;
            5'd12: v = 946;  5'd13: v = 980;  5'd14: v = 1004; 5'd15: v = 1019;
            5'd16: v = 1024;
            default: v = 0;
        endcase
        return SAMP_W'(v) <<< (FRAC_W - 10);
    endfunction

    // Full-cycle sine from quadrant symmetry.
    function automatic logic signed [SAMP_W-1:0] sine(input logic [PHASE_W-1:0] p);
        logic [4:0] idx;
        logic signed [SAMP_W-1:0] mag;
        idx = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
        mag = quarter(idx);
        return p[5] ? -mag : mag;
    endfunction

    // Advance the phase one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Carrier samples and the symbol slot flag for the current phase.
    always_comb begin
        slot  = (phase == '1);
        sin_s = sine(phase);
        cos_s = sine(phase + QTR);
    end
endmodule

// File: rtl/qam_carrier_mod.sv
// Top of the selectable modulator: captures a symbol and scheme once per
// carrier cycle, maps them to amplitudes and mixes them with the carrier.
// Assumes: one sample per clock; outputs are registered, one clock after
// the phase they belong to.
module qam_carrier_mod
    import qam_mod_pkg::*;
#(
    parameter int SAMP_W = 15,
    parameter int FRAC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BTN_W-1:0]         btn,
    input  logic                     sym_valid,
    input  logic [SYM_W-1:0]         sym_data,
    output logic                     sym_req,
    output logic signed [SAMP_W-1:0] mod_i,
    output logic signed [SAMP_W-1:0] mod_q
);
    localparam int PROD_W = 2 * SAMP_W;
    localparam int HALF   = 1 << (FRAC_W - 1);

    scheme_e                  scheme_dec;
    scheme_e                  scheme_act;
    logic [SYM_W-1:0]         sym_act;
    logic                     live;
    logic                     slot;
    logic signed [SAMP_W-1:0] amp_i, amp_q, cos_s, sin_s;
    logic signed [SAMP_W-1:0] amp  [2];
    logic signed [SAMP_W-1:0] carr [2];

    qam_scheme_decode u_dec (
        .btn    (btn),
        .scheme (scheme_dec)
    );

    qam_carrier_nco #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot),
        .cos_s (cos_s),
        .sin_s (sin_s)
    );

    qam_level_map #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) u_map (
        .scheme (scheme_act),
        .sym    (sym_act),
        .live   (live),
        .amp_i  (amp_i),
        .amp_q  (amp_q)
    );

    // Take symbol, validity and scheme only at the end of a carrier cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scheme_act <= SCH_BPSK;
            sym_act    <= '0;
            live       <= 1'b0;
        end else if (slot) begin
            scheme_act <= scheme_dec;
            sym_act    <= sym_data;
            live       <= sym_valid;
        end
    end

    // Pair each amplitude with its carrier: I with cosine, Q with sine.
    always_comb begin
        amp[0]  = amp_i;
        amp[1]  = amp_q;
        carr[0] = cos_s;
        carr[1] = sin_s;
    end

    for (genvar b = 0; b < 2; b++) begin : g_branch
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] prod_rnd;
        logic signed [SAMP_W-1:0] smp_q;

        // Full product, rounded half up back to FRAC_W fraction bits.
        always_comb begin
            prod     = amp[b] * carr[b];
            prod_rnd = (prod + PROD_W'(HALF)) >>> FRAC_W;
        end

        // Register the branch output.
        always_ff @(posedge clk) begin
            if (!rst_n) smp_q <= '0;
            else        smp_q <= prod_rnd[SAMP_W-1:0];
        end
    end

    assign sym_req = slot;
    assign mod_i   = g_branch[0].smp_q;
    assign mod_q   = g_branch[1].smp_q;
endmodule

// File: rtl/qam_carrier_mod_chk.sv
// Property checker for the modulator, bound into every instance.
// Keeps its own cycle counter to track the slot rhythm.
module qam_carrier_mod_chk #(
    parameter int SAMP_W = 15,
    parameter int FRAC_W = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sym_req,
    input logic                     sym_valid,
    input logic [1:0]               scheme_act,
    input logic signed [SAMP_W-1:0] mod_i,
    input logic signed [SAMP_W-1:0] mod_q
);
    localparam int LIM = 15 << FRAC_W;

    logic [5:0] cyc;

    // Independent count of clocks since reset, modulo 64.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    AST_SLOT_RHYTHM: assert property (@(posedge clk) disable iff (!rst_n)
        sym_req == (cyc == 6'd63)); // R2

    AST_SCHEME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_req |=> $stable(scheme_act)); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_req && !sym_valid) |=> ##1 (mod_i == 0 && mod_q == 0)); // R4

    AST_BPSK_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme_act == 2'd0) |=> (mod_q == 0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mod_i) <= LIM) && (int'(mod_i) >= -LIM) &&
        (int'(mod_q) <= LIM) && (int'(mod_q) >= -LIM)); // R10
endmodule

bind qam_carrier_mod qam_carrier_mod_chk #(.SAMP_W(SAMP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_req    (sym_req),
    .sym_valid  (sym_valid),
    .scheme_act (scheme_act),
    .mod_i      (mod_i),
    .mod_q      (mod_q)
);

// File: tb/qam_carrier_mod_tb.sv
`timescale 1ns/1ps
module qam_carrier_mod_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        btn = 4'b0000;
    logic              sym_valid = 1'b0;
    logic [7:0]        sym_data = 8'h00;
    logic              sym_req;
    logic signed [14:0] mod_i, mod_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    qam_carrier_mod u_dut (
        .clk(clk), .rst_n(rst_n), .btn(btn), .sym_valid(sym_valid),
        .sym_data(sym_data), .sym_req(sym_req), .mod_i(mod_i), .mod_q(mod_q)
    );

    // Row: {buttons, symbol}. Every row exercises R1 decode, R9 carrier and R10 rounding.
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        {4'b0000, 8'h01}, {4'b1000, 8'hFE}, {4'b1100, 8'h01}, {4'b1000, 8'h00},
        {4'b0100, 8'h00}, {4'b0100, 8'h01}, {4'b0100, 8'h02}, {4'b0100, 8'h03},
        {4'b0010, 8'h00}, {4'b0010, 8'h1B}, {4'b0010, 8'h4E}, {4'b0010, 8'h07},
        {4'b0001, 8'h10}, {4'b0001, 8'h9D}, {4'b0001, 8'h7A}, {4'b0001, 8'h36},
        {4'b0001, 8'hC8}, {4'b0001, 8'h99}
    };

    function automatic int exp_sch(input logic [3:0] b);
        case (b)
            4'b0100: return 1;
            4'b0010: return 2;
            4'b0001: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int lvl16(input logic [1:0] b);
        case (b)
            2'b00: return -896;
            2'b01: return -320;
            2'b11: return 320;
            default: return 896;
        endcase
    endfunction

    function automatic int lvl256(input logic [3:0] n);
        int l;
        case (n)
            4'b0001: l = -15; 4'b0000: l = -13; 4'b0010: l = -11; 4'b0011: l = -9;
            4'b0111: l = -7;  4'b0110: l = -5;  4'b0100: l = -3;  4'b0101: l = -1;
            4'b1101: l = 1;   4'b1100: l = 3;   4'b1110: l = 5;   4'b1111: l = 7;
            4'b1011: l = 9;   4'b1010: l = 11;  4'b1000: l = 13;  default: l = 15;
        endcase
        return l * 1024;
    endfunction

    function automatic int carr_sin(input int k);
        real v;
        v = $sin(2.0 * 3.14159265358979 * k / 64.0) * 1024.0;
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int rnd(input int a, input int c);
        int p;
        p = a * c;
        return (p + 512) >>> 10;
    endfunction

    // Offer one symbol at the next slot, then compare all 64 samples.
    task automatic run_slot(input logic [3:0] b, input logic [7:0] s, input bit vld,
                            input bit disturb, input string tag);
        int sch, ai, aq, ei, eq, bad_i, bad_q, gi, gq, wi, wq;
        sch = exp_sch(b);
        ai = 0; aq = 0;
        if (vld) begin
            case (sch)
                0: ai = s[0] ? 128 : -128;
                1: begin ai = s[1] ? 192 : -192; aq = s[0] ? 192 : -192; end
                2: begin ai = lvl16(s[3:2]); aq = lvl16(s[1:0]); end
                default: begin ai = lvl256(s[7:4]); aq = lvl256(s[3:0]); end
            endcase
        end
        while (!sym_req) @(negedge clk);
        btn = b; sym_data = s; sym_valid = vld;
        @(posedge clk);
        @(negedge clk);
        sym_valid = 1'b0;
        bad_i = 0; bad_q = 0; gi = 0; gq = 0; wi = 0; wq = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            ei = rnd(ai, carr_sin(k + 16));
            eq = rnd(aq, carr_sin(k));
            if (int'(mod_i) != ei && bad_i == 0) begin gi = int'(mod_i); wi = ei; end
            if (int'(mod_q) != eq && bad_q == 0) begin gq = int'(mod_q); wq = eq; end
            if (int'(mod_i) != ei) bad_i++;
            if (int'(mod_q) != eq) bad_q++;
            if (disturb && k == 10) begin
                btn = (b == 4'b0001) ? 4'b0100 : 4'b0001;
                sym_valid = 1'b1;
                sym_data = ~s;
            end
            if (disturb && k == 11) begin
                btn = b;
                sym_valid = 1'b0;
                sym_data = s;
            end
        end
        checks += 2;
        if (bad_i != 0) begin
            failures++;
            $display("FAIL %s I btn=%b sym=%h: actual %0d expected %0d", tag, b, s, gi, wi);
        end
        if (bad_q != 0) begin
            failures++;
            $display("FAIL %s Q btn=%b sym=%h: actual %0d expected %0d", tag, b, s, gq, wq);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        string tag;
        bit quiet;
        repeat (5) @(negedge clk);
        // R11: reset state
        checks++;
        if (mod_i != 0 || mod_q != 0 || sym_req) begin
            failures++;
            $display("FAIL R11 reset: actual i=%0d q=%0d req=%b expected 0 0 0", mod_i, mod_q, sym_req);
        end
        rst_n = 1'b1;
        n = 0;
        quiet = 1'b1;
        while (!sym_req && n < 200) begin
            @(negedge clk);
            n++;
            if (mod_i != 0 || mod_q != 0) quiet = 1'b0;
        end
        // R11 / R2: first slot 63 clocks after release, silent until then
        checks++;
        if (n != 63) begin
            failures++;
            $display("FAIL R11 first slot: actual %0d expected 63", n);
        end
        checks++;
        if (!quiet) begin
            failures++;
            $display("FAIL R11 idle output: actual nonzero expected 0");
        end

        for (int v = 0; v < NV; v++) begin
            case (exp_sch(VEC[v][11:8]))
                0: tag = (VEC[v][11:8] == 4'b1000) ? "R5" : "R1/R5";
                1: tag = "R6";
                2: tag = "R7";
                default: tag = "R8";
            endcase
            run_slot(VEC[v][11:8], VEC[v][7:0], 1'b1, 1'b0, tag);
        end

        // R2: slot spacing of 64 clocks
        n = 0;
        while (!sym_req && n < 200) begin @(negedge clk); n++; end
        checks++;
        if (n != 63) begin
            failures++;
            $display("FAIL R2 slot spacing: actual %0d expected 63", n);
        end

        // R3 and R4: mid-symbol button change and stray valid are ignored
        run_slot(4'b0001, 8'h9D, 1'b1, 1'b1, "R3/R4");
        run_slot(4'b0010, 8'h4E, 1'b1, 1'b1, "R3/R4");
        // R4: no symbol at the slot gives silence
        run_slot(4'b0100, 8'h03, 1'b0, 1'b1, "R4");
        // R8 / R10: extreme levels after an idle cycle
        run_slot(4'b0001, 8'h11, 1'b1, 1'b0, "R8/R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule